// File: doc/BRIEF.md
# Two-Way Parallel Successive-Cancellation Polar Decoder

This block decodes one polar codeword of length N (8 to 32) from N signed fixed-point log-likelihood ratios. The codeword is x = u·B·F^n, where u is the source vector, B is the bit-reversal permutation and F^n is the n-fold Kronecker power of the 2x2 kernel. This structure lets the received vector be split into two halves, and each half is an independent half-length polar code. Two successive-cancellation engines run side by side, one per half, and each decides its own half-length source vector. A small recombination stage then rebuilds the N source-bit estimates with an XOR and a bit-reversed placement.

A frame is accepted through a valid/ready handshake, together with a mask that names the frozen source positions. Frozen positions carry zero. When both engines have finished, the block raises a one-cycle done pulse. At the same time it presents the full source estimate and the K information bits, packed in ascending source index. Each engine uses min-sum arithmetic with saturation to the LLR width. Because both halves are decoded at once, latency is about half that of a single full-length engine of the same style.

Top module: `polar2_par_dec`

## Requirements
- R1: A frame is taken on a rising clock edge where in_valid and in_ready are both 1. in_ready is 0 from that edge until the edge that raises out_done, and it returns to 1 on that same edge.
- R2: out_done is high for exactly one cycle. It rises (N/2)*log2(N/2)+1 clock edges after the accepting edge, which is 9 edges for N=8.
- R3: For a noise-free codeword x = u·B·F^n, the LLR for a code bit of 0 is positive and for a code bit of 1 is negative, and LLR j sits at in_llr bits [j*W +: W]. For any such codeword whose frozen source bits are 0, out_u equals u, with out_u bit k holding source bit k.
- R4: Every source position whose in_frozen bit is 1 reads 0 on out_u, whatever the LLRs say.
- R5: A final LLR of zero is decided as bit 0, so an all-zero LLR vector with no frozen bits yields out_u = 0.
- R6: The min-sum f and g updates saturate to the signed W-bit range instead of wrapping. Noise-free frames at the extreme values (most negative for a 1, most positive for a 0) still decode exactly.
- R7: out_info bit i holds the source bit at the i-th non-frozen position, counted from index 0 upward. When fewer than K positions are non-frozen, the unused upper bits are 0.
- R8: Each half is decoded from its own N/2 LLRs. If only the last source bit is information, one weak wrong LLR in either half is outvoted by the strong LLRs of that half.
- R9: With synchronous active-high reset asserted, the block returns to idle. After reset, in_ready is 1, out_done is 0 and out_u is 0, even when reset arrives in the middle of a decode, and the next frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame present on in_llr and in_frozen |
| in_ready | output | 1 | Block idle and able to take a frame |
| in_llr | input | N*W | N signed LLRs, LLR j at bits [j*W +: W] |
| in_frozen | input | N | Bit k set marks source bit k as frozen |
| out_done | output | 1 | One-cycle pulse when the outputs hold a new result |
| out_u | output | N | Source-bit estimates, bit k is source bit k |
| out_info | output | K | Information bits in ascending source index |

## Verification
The bench targets the frozen-mask derivation for the two halves. A design that freezes a first-half position when only one of its two feeding source bits is frozen would drop the repetition bit in the low-rate noisy case, and one that decides frozen positions from the LLR would show ones where the mask demands zeros. Extreme-valued LLRs exercise the saturating g update: a wrapping adder flips signs and corrupts whole frames. The zero-LLR frame catches a tie broken toward 1. A reset in mid-decode and the exact done latency catch an engine that keeps stale state or whose finish flag is set too early.

// File: rtl/polar2_pkg.sv
package polar2_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrl_state_t;

  // reverse the low 'bits' bits of v
  function automatic int bitrev(input int v, input int bits);
    int r;
    r = 0;
    for (int b = 0; b < bits; b++) begin
      if (((v >> b) & 1) != 0) r = r | (1 << (bits - 1 - b));
    end
    return r;
  endfunction

endpackage

// File: rtl/polar2_sc_half.sv
module polar2_sc_half #(
  parameter int H = 4,
  parameter int W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [H*W-1:0] llr_in,
  input  logic [H-1:0]   frozen,
  output logic           fin,
  output logic [H-1:0]   bits
);
  localparam int HH   = $clog2(H);
  localparam int JW   = (HH < 1) ? 1 : HH;
  localparam int LVW  = $clog2(HH + 1);
  localparam int MAXI = (1 << (W - 1)) - 1;
  localparam int MINI = -(1 << (W - 1));

  logic signed [W-1:0] lvl_q [HH:1][H];
  logic [JW-1:0]  j_q;
  logic [LVW-1:0] l_q;
  logic           busy_q, fin_q;
  logic [H-1:0]   w_q;

  logic [H-1:0]        ps;
  logic signed [W-1:0] nxt [H];
  logic                dec;

  function automatic logic signed [W-1:0] sat(input logic signed [W:0] v);
    if (int'(v) > MAXI) return W'(MAXI);
    if (int'(v) < MINI) return W'(MINI);
    return v[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] f_upd(input logic signed [W-1:0] a,
                                                input logic signed [W-1:0] b);
    logic signed [W:0] ma, mb, m;
    ma = (a < 0) ? -{a[W-1], a} : {a[W-1], a};
    mb = (b < 0) ? -{b[W-1], b} : {b[W-1], b};
    m  = (ma < mb) ? ma : mb;
    return sat((a[W-1] ^ b[W-1]) ? -m : m);
  endfunction

  function automatic logic signed [W-1:0] g_upd(input logic signed [W-1:0] a,
                                                input logic signed [W-1:0] b,
                                                input logic s);
    logic signed [W:0] ea, eb;
    ea = {a[W-1], a};
    eb = {b[W-1], b};
    return sat(s ? (eb - ea) : (eb + ea));
  endfunction

  // re-encoded codeword of the left sibling of the current path node
  function automatic logic [H-1:0] part_sum(input logic [H-1:0] w, input int j, input int l);
    logic [H-1:0] seg;
    int base, span;
    base = (j >> (l + 1)) << (l + 1);
    span = 1 << l;
    seg  = '0;
    for (int k = 0; k < H; k++) begin
      if (k < span && base + k < H) seg[k] = w[base + k];
    end
    for (int s = 1; s < H; s = s * 2) begin
      for (int i = 0; i < H; i++) begin
        if ((i & s) == 0 && i + s < H) seg[i] = seg[i] ^ seg[i + s];
      end
    end
    return seg;
  endfunction

  always_comb begin
    int up, half;
    up   = int'(l_q) + 1;
    half = 1 << l_q;
    ps   = part_sum(w_q, int'(j_q), int'(l_q));
    for (int i = 0; i < H; i++) begin
      if (j_q[l_q])
        nxt[i] = g_upd(lvl_q[up][i], lvl_q[up][(i + half) % H], ps[i]);
      else
        nxt[i] = f_upd(lvl_q[up][i], lvl_q[up][(i + half) % H]);
    end
    dec = frozen[j_q] ? 1'b0 : nxt[0][W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      j_q    <= '0;
      l_q    <= '0;
      w_q    <= '0;
    end else if (start) begin
      for (int i = 0; i < H; i++) lvl_q[HH][i] <= llr_in[i*W +: W];
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
      j_q    <= '0;
      l_q    <= LVW'(HH - 1);
      w_q    <= '0;
    end else if (busy_q) begin
      if (l_q != '0) begin
        for (int i = 0; i < H; i++) lvl_q[l_q][i] <= nxt[i];
        l_q <= l_q - 1'b1;
      end else begin
        w_q[j_q] <= dec;
        if (int'(j_q) == H - 1) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end else begin
          j_q <= j_q + 1'b1;
          l_q <= LVW'(HH - 1);
        end
      end
    end
  end

  assign fin  = fin_q;
  assign bits = w_q;

  // R4: a frozen position is written as 0 regardless of its LLR
  p_frozen_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && l_q == '0 && frozen[j_q]) |=> !w_q[$past(j_q)]);

  // R3: source bits of a half are decided one at a time in index order
  p_index_order_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && l_q == '0 && int'(j_q) != H - 1) |=> (int'(j_q) == int'($past(j_q)) + 1));

endmodule

// File: rtl/polar2_merge.sv
module polar2_merge #(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N-1:0]   frozen,
  input  logic [N/2-1:0] wa,
  input  logic [N/2-1:0] wb,
  output logic [N-1:0]   u_out,
  output logic [K-1:0]   info_out,
  output logic           done_out
);
  import polar2_pkg::*;
  localparam int H  = N / 2;
  localparam int HH = $clog2(H);

  logic [N-1:0] u_c;
  logic [K-1:0] info_c;

  always_comb begin
    int r, cnt;
    u_c = '0;
    for (int i = 0; i < H; i++) begin
      r = bitrev(i, HH);
      u_c[2*r]     = (wa[i] ^ wb[i]) & ~frozen[2*r];
      u_c[2*r + 1] = wb[i] & ~frozen[2*r + 1];
    end
    info_c = '0;
    cnt    = 0;
    for (int k = 0; k < N; k++) begin
      if (!frozen[k]) begin
        if (cnt < K) info_c[cnt] = u_c[k];
        cnt = cnt + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_out    <= '0;
      info_out <= '0;
      done_out <= 1'b0;
    end else begin
      done_out <= load;
      if (load) begin
        u_out    <= u_c;
        info_out <= info_c;
      end
    end
  end

  // R4: frozen positions read zero whenever a result is presented
  p_frozen_out_r4: assert property (@(posedge clk) disable iff (rst)
    done_out |-> ((u_out & frozen) == '0));

endmodule

// File: rtl/polar2_par_dec.sv
module polar2_par_dec #(
  parameter int N = 8,
  parameter int W = 6,
  parameter int K = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*W-1:0] in_llr,
  input  logic [N-1:0]   in_frozen,
  output logic           out_done,
  output logic [N-1:0]   out_u,
  output logic [K-1:0]   out_info
);
  import polar2_pkg::*;
  localparam int H  = N / 2;
  localparam int HH = $clog2(H);

  ctrl_state_t  state_q;
  logic         ready_q;
  logic [N-1:0] frz_q;
  logic         start, fin_a, fin_b, load;
  logic [H-1:0] frz_a, frz_b, w_a, w_b;

  assign start = in_valid && ready_q;
  assign load  = (state_q == ST_RUN) && fin_a && fin_b;

  // a half-code position is frozen only when every source bit feeding it is
  always_comb begin
    int r;
    for (int i = 0; i < H; i++) begin
      r = bitrev(i, HH);
      frz_a[i] = frz_q[2*r] & frz_q[2*r + 1];
      frz_b[i] = frz_q[2*r + 1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
      frz_q   <= '0;
    end else if (start) begin
      state_q <= ST_RUN;
      ready_q <= 1'b0;
      frz_q   <= in_frozen;
    end else if (load) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b1;
    end
  end

  polar2_sc_half #(.H(H), .W(W)) u_half_lo (
    .clk(clk), .rst(rst), .start(start),
    .llr_in(in_llr[H*W-1:0]), .frozen(frz_a), .fin(fin_a), .bits(w_a)
  );

  polar2_sc_half #(.H(H), .W(W)) u_half_hi (
    .clk(clk), .rst(rst), .start(start),
    .llr_in(in_llr[N*W-1:H*W]), .frozen(frz_b), .fin(fin_b), .bits(w_b)
  );

  polar2_merge #(.N(N), .K(K)) u_merge (
    .clk(clk), .rst(rst), .load(load), .frozen(frz_q),
    .wa(w_a), .wb(w_b), .u_out(out_u), .info_out(out_info), .done_out(out_done)
  );

  assign in_ready = ready_q;

  // R1: acceptance drops ready on the next cycle
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R1: ready is back when the result is presented
  p_ready_back_r1: assert property (@(posedge clk) disable iff (rst)
    out_done |-> in_ready);

  // R2: done is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

endmodule

// File: tb/polar2_par_dec_test.sv
module polar2_par_dec_test;
  localparam int N  = 8;
  localparam int W  = 6;
  localparam int K  = 4;
  localparam int H  = N / 2;
  localparam int LAT = H * $clog2(H) + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [N*W-1:0] in_llr = '0;
  logic [N-1:0]   in_frozen = '0;
  logic           out_done;
  logic [N-1:0]   out_u;
  logic [K-1:0]   out_info;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  polar2_par_dec #(.N(N), .W(W), .K(K)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .in_frozen(in_frozen), .out_done(out_done),
    .out_u(out_u), .out_info(out_info)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rev3(input int v);
    return ((v & 1) << 2) | (v & 2) | ((v >> 2) & 1);
  endfunction

  // x = u * B * F^n
  function automatic logic [N-1:0] encode(input logic [N-1:0] u);
    logic [N-1:0] x;
    for (int i = 0; i < N; i++) x[i] = u[rev3(i)];
    for (int s = 1; s < N; s = s * 2)
      for (int i = 0; i < N; i++)
        if ((i & s) == 0) x[i] = x[i] ^ x[i + s];
    return x;
  endfunction

  function automatic logic [K-1:0] info_of(input logic [N-1:0] u, input logic [N-1:0] m);
    logic [K-1:0] r;
    int c;
    r = '0;
    c = 0;
    for (int k = 0; k < N; k++)
      if (!m[k]) begin
        if (c < K) r[c] = u[k];
        c++;
      end
    return r;
  endfunction

  function automatic logic [N*W-1:0] llr_of(input logic [N-1:0] x, input int mag);
    logic [N*W-1:0] v;
    logic signed [W-1:0] t;
    for (int i = 0; i < N; i++) begin
      t = W'(mag);
      v[i*W +: W] = x[i] ? -t : t;
    end
    return v;
  endfunction

  logic [N-1:0] got_u;
  logic [K-1:0] got_info;
  int got_lat, ready_bad, done_twice;

  task automatic run_decode(input logic [N*W-1:0] llr, input logic [N-1:0] m);
    int n;
    @(negedge clk);
    in_llr = llr;
    in_frozen = m;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    n = 0;
    ready_bad = 0;
    while (n < 100) begin
      @(posedge clk);
      #1 n++;
      if (out_done) break;
      if (in_ready) ready_bad++;
    end
    got_lat  = n;
    got_u    = out_u;
    got_info = out_info;
    @(posedge clk);
    #1 done_twice = out_done ? 1 : 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] u, m, x;
    logic [N*W-1:0] l;
    logic signed [W-1:0] t;
    void'($urandom(32'd4242));

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R9 reset state
    check(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    check(out_done == 1'b0, "R9 done after reset", out_done, 0);
    check(out_u == '0, "R9 out_u after reset", out_u, 0);

    // R5 zero LLRs, nothing frozen
    run_decode('0, '0);
    check(got_u == '0, "R5 zero llr decides 0", got_u, 0);
    // R2 latency and pulse, R1 ready low while busy
    check(got_lat == LAT, "R2 done latency", got_lat, LAT);
    check(done_twice == 0, "R2 done single cycle", done_twice, 0);
    check(ready_bad == 0, "R1 ready low while busy", ready_bad, 0);

    // R4 all frozen with random LLRs, R7 info zero
    for (int i = 0; i < N; i++) l[i*W +: W] = W'($urandom);
    run_decode(l, '1);
    check(got_u == '0, "R4 all frozen gives zero", got_u, 0);
    check(got_info == '0, "R7 info empty when all frozen", got_info, 0);

    // R4 frozen positions forced to zero although the LLRs claim a one
    for (int t2 = 0; t2 < 20; t2++) begin
      m = N'($urandom) | N'(1);
      u = N'($urandom) | m;
      run_decode(llr_of(encode(u), 20), m);
      check((got_u & m) == '0, "R4 frozen reads zero", got_u & m, 0);
    end

    // R6 extreme values: -2^(W-1) for a one, 2^(W-1)-1 for a zero
    for (int t2 = 0; t2 < 20; t2++) begin
      u = N'($urandom);
      x = encode(u);
      for (int i = 0; i < N; i++) begin
        t = x[i] ? W'(-(1 << (W - 1))) : W'((1 << (W - 1)) - 1);
        l[i*W +: W] = t;
      end
      run_decode(l, '0);
      check(got_u == u, "R6 saturated frame decodes", got_u, u);
    end

    // R8 repetition of the last source bit with one weak flip in each half
    for (int side = 0; side < 2; side++) begin
      l = llr_of(N'('1), 20);
      t = W'(3);
      l[(side * H + 2)*W +: W] = t;
      run_decode(l, N'(8'h7F));
      check(got_u == N'(8'h80), "R8 weak flip outvoted u", got_u, 8'h80);
      check(got_info == K'(1), "R8 weak flip outvoted info", got_info, 1);
    end

    // R3 / R7 constrained random noise-free frames
    for (int t2 = 0; t2 < 200; t2++) begin
      m = N'($urandom);
      u = N'($urandom) & ~m;
      x = encode(u);
      for (int i = 0; i < N; i++) begin
        int mag;
        mag = 1 + int'($urandom % 31);
        t = W'(mag);
        l[i*W +: W] = x[i] ? -t : t;
      end
      run_decode(l, m);
      check(got_u == u, "R3 random frame out_u", got_u, u);
      check(got_info == info_of(u, m), "R7 random frame info", got_info, info_of(u, m));
      if (t2 < 5) check(got_lat == LAT, "R2 latency random", got_lat, LAT);
    end

    // R9 reset in the middle of a decode
    @(negedge clk);
    in_llr = llr_of(encode(N'(8'h5A)), 15);
    in_frozen = '0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(in_ready == 1'b1, "R9 ready after mid reset", in_ready, 1);
    begin
      int seen;
      seen = 0;
      repeat (12) begin
        @(posedge clk);
        #1 if (out_done) seen++;
      end
      check(seen == 0, "R9 no done after mid reset", seen, 0);
    end
    run_decode(llr_of(encode(N'(8'h3C)), 12), '0);
    check(got_u == N'(8'h3C), "R9 decode after mid reset", got_u, 8'h3C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule